// File: doc/BRIEF.md
# Packed Element Rearrangement Unit

This unit moves sub-word elements of two 64-bit operands into one 64-bit result word. Four kinds of operation are covered. Mix operations interleave either the even-indexed or the odd-indexed elements of both operands. Unpack operations interleave the elements of the lower or upper 32-bit half of both operands. Pack operations narrow wider elements of both operands with signed or unsigned saturation. Mux operations copy elements of the first operand into arbitrary result positions: for halfwords the positions come from an 8-bit immediate, and for bytes the immediate selects one of five fixed patterns.

Elements are numbered from 0 at the least-significant end of a word. Combinations of operation and element size that are not defined give an all-zero result and set an illegal flag. With the default parameter the result and the flag are registered: an operation presented at one rising edge appears at the outputs after that edge. With `REG_OUT = 0` the unit is purely combinational.

Top module: `elem_shuffle_unit`

## Requirements
- R1: Mix-even (opcode 0) with element size e (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) puts element 2k of src_b into result element 2k and element 2k of src_a into result element 2k+1.
- R2: Mix-odd (opcode 1) puts element 2k+1 of src_b into result element 2k and element 2k+1 of src_a into result element 2k+1, for the same three sizes.
- R3: Unpack-low (opcode 2) puts element k of src_b into result element 2k and element k of src_a into result element 2k+1, for every element k that lies in bits 31:0.
- R4: Unpack-high (opcode 3) does the same with the elements that lie in bits 63:32: result element 2k comes from src_b element k+n/2 and element 2k+1 from src_a element k+n/2, where n is the element count.
- R5: Signed pack (opcode 4) with esize 0 narrows each signed 16-bit element to 8 bits, clamped to [-128, 127]; with esize 1 it narrows each signed 32-bit element to 16 bits, clamped to [-32768, 32767]. The elements of src_a fill result bits 31:0 and those of src_b fill bits 63:32, each in ascending order.
- R6: Unsigned pack (opcode 5) with esize 0 treats each 16-bit element as signed and clamps it to [0, 255], with the same placement as R5.
- R7: Halfword mux (opcode 6, esize 1) writes into result halfword k the src_a halfword selected by imm[2k+1:2k].
- R8: Byte mux (opcode 6, esize 0) picks a pattern from imm[3:0] (all other imm bits ignored). Result byte i is taken from src_a byte j, where j is 0 for value 0 (broadcast), i XOR 1 for value 8 (pair swap), {i[0],i[2],i[1]} for value 9 (shuffle), {i[1],i[0],i[2]} for value 10 (alternate), and 7-i for value 11 (reverse).
- R9: Opcode 7, esize 3 for opcodes 0 to 3, esize other than 0 or 1 for opcode 4, esize other than 0 for opcode 5, esize other than 0 or 1 for opcode 6, and any other imm[3:0] value for byte mux all give result 0 with illegal = 1. Every defined combination gives illegal = 0.
- R10: With REG_OUT = 1, result and illegal show the operation sampled at the previous rising edge, and both are 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| opcode | input | 3 | 0 mix-even, 1 mix-odd, 2 unpack-low, 3 unpack-high, 4 signed pack, 5 unsigned pack, 6 mux, 7 undefined |
| esize | input | 2 | Element size code: 0 byte, 1 halfword, 2 word |
| imm | input | 8 | Mux control immediate |
| result | output | 64 | Rearranged word |
| illegal | output | 1 | High for an undefined opcode and size combination |

## Verification
In one cycle, saturation and element placement must both be correct. A pack puts clamped values into positions chosen by operand and index, so an operand swap or an order error can hide behind a correct clamp. Directed vectors load both operands with boundary values (0x7F, 0x80, 0xFF7F, 0xFFFF, 0x0100, 0x8000_0000, 0x0000_8000) and a different value in each lane, so each result lane shows its source and its clamp together. A behavioural reference model, built on element lists and integer arithmetic, judges these vectors and a random opcode stream on every cycle. The stream also mixes legal and undefined combinations in consecutive cycles, so the clearing of the illegal flag is covered as well.

// File: rtl/elem_shuffle_unit.sv
module elem_shuffle_unit #(
  parameter int REG_OUT = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] src_a,
  input  logic [63:0] src_b,
  input  logic [2:0]  opcode,
  input  logic [1:0]  esize,
  input  logic [7:0]  imm,
  output logic [63:0] result,
  output logic        illegal
);
  localparam logic [2:0] OP_MIXE = 3'd0;
  localparam logic [2:0] OP_MIXO = 3'd1;
  localparam logic [2:0] OP_UNPL = 3'd2;
  localparam logic [2:0] OP_UNPH = 3'd3;
  localparam logic [2:0] OP_PKS  = 3'd4;
  localparam logic [2:0] OP_PKU  = 3'd5;
  localparam logic [2:0] OP_MUX  = 3'd6;

  function automatic logic [63:0] weave(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] sz, input logic unp, input logic hi);
    logic [63:0] r;
    logic [5:0]  pos, sh, e, k, off, half, se, sb;
    r    = '0;
    sh   = 6'd3 + {4'd0, sz};
    half = 6'd4 >> sh[1:0] - 6'd0;
    half = 6'd4 >> {4'd0, sz};
    for (int i = 0; i < 64; i++) begin
      pos = 6'(i);
      e   = pos >> sh;
      off = pos & ((6'd1 << sh) - 6'd1);
      k   = e >> 1;
      se  = unp ? (k + (hi ? half : 6'd0)) : ((k << 1) | {5'd0, hi});
      sb  = (se << sh) | off;
      r[i] = e[0] ? a[sb] : b[sb];
    end
    return r;
  endfunction

  function automatic logic [7:0] clamp8(input logic [15:0] v, input logic sgn);
    if (sgn) begin
      if ($signed(v) > 16'sd127)       return 8'h7F;
      else if ($signed(v) < -16'sd128) return 8'h80;
      else                             return v[7:0];
    end else begin
      if (v[15])              return 8'h00;
      else if (v > 16'd255)   return 8'hFF;
      else                    return v[7:0];
    end
  endfunction

  function automatic logic [15:0] clamp16(input logic [31:0] v);
    if ($signed(v) > 32'sd32767)       return 16'h7FFF;
    else if ($signed(v) < -32'sd32768) return 16'h8000;
    else                               return v[15:0];
  endfunction

  function automatic logic [63:0] narrow8(input logic [63:0] a, input logic [63:0] b, input logic sgn);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      r[8*i +: 8]      = clamp8(a[16*i +: 16], sgn);
      r[32 + 8*i +: 8] = clamp8(b[16*i +: 16], sgn);
    end
    return r;
  endfunction

  function automatic logic [63:0] narrow16(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 2; i++) begin
      r[16*i +: 16]      = clamp16(a[32*i +: 32]);
      r[32 + 16*i +: 16] = clamp16(b[32*i +: 32]);
    end
    return r;
  endfunction

  function automatic logic [63:0] hperm(input logic [63:0] a, input logic [7:0] ctl);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < 4; k++)
      r[16*k +: 16] = a[{ctl[2*k +: 2], 4'b0000} +: 16];
    return r;
  endfunction

  function automatic logic [63:0] bperm(input logic [63:0] a, input logic [3:0] pat);
    logic [63:0] r;
    logic [2:0]  i3, j;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      i3 = 3'(i);
      case (pat)
        4'h8:    j = i3 ^ 3'd1;
        4'h9:    j = {i3[0], i3[2], i3[1]};
        4'hA:    j = {i3[1], i3[0], i3[2]};
        4'hB:    j = ~i3;
        default: j = 3'd0;
      endcase
      r[8*i +: 8] = a[{j, 3'b000} +: 8];
    end
    return r;
  endfunction

  logic [63:0] res_c;
  logic        ill_c;

  always_comb begin
    res_c = '0;
    ill_c = 1'b0;
    case (opcode)
      OP_MIXE, OP_MIXO, OP_UNPL, OP_UNPH:
        if (esize == 2'd3) ill_c = 1'b1;
        else res_c = weave(src_a, src_b, esize, opcode[1], opcode[0]);
      OP_PKS:
        if (esize == 2'd0)      res_c = narrow8(src_a, src_b, 1'b1);
        else if (esize == 2'd1) res_c = narrow16(src_a, src_b);
        else                    ill_c = 1'b1;
      OP_PKU:
        if (esize == 2'd0) res_c = narrow8(src_a, src_b, 1'b0);
        else               ill_c = 1'b1;
      OP_MUX:
        if (esize == 2'd1) res_c = hperm(src_a, imm);
        else if (esize == 2'd0 && (imm[3:0] == 4'h0 || (imm[3:0] >= 4'h8 && imm[3:0] <= 4'hB)))
          res_c = bperm(src_a, imm[3:0]);
        else ill_c = 1'b1;
      default: ill_c = 1'b1;
    endcase
  end

  generate
    if (REG_OUT != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result  <= '0;
          illegal <= 1'b0;
        end else begin
          result  <= res_c;
          illegal <= ill_c;
        end
      end
    end else begin : g_comb
      assign result  = res_c;
      assign illegal = ill_c;
    end
  endgenerate
endmodule

module esu_chk #(
  parameter int REG_OUT = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] src_a,
  input logic [63:0] src_b,
  input logic [2:0]  opcode,
  input logic [1:0]  esize,
  input logic [7:0]  imm,
  input logic [63:0] result,
  input logic        illegal
);
  generate
    if (REG_OUT != 0) begin : g_props
      // R9
      illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> result == 64'd0);
      // R9
      undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode) == 3'd7) |-> illegal);
      // R3
      unpack_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode) == 3'd2 && $past(esize) == 2'd2)
          |-> result == {$past(src_a[31:0]), $past(src_b[31:0])});
      // R2
      mix_odd_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode) == 3'd1 && $past(esize) == 2'd2)
          |-> result == {$past(src_a[63:32]), $past(src_b[63:32])});
      // R7
      hmux_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode) == 3'd6 && $past(esize) == 2'd1 && $past(imm) == 8'hE4)
          |-> result == $past(src_a));
      // R8
      bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode) == 3'd6 && $past(esize) == 2'd0 && $past(imm[3:0]) == 4'h0)
          |-> result == {8{$past(src_a[7:0])}});
      // R10
      reset_chk: assert property (@(posedge clk) !rst_n |=> (result == 64'd0 && !illegal) || rst_n);
    end
  endgenerate
endmodule

bind elem_shuffle_unit esu_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .opcode(opcode),
  .esize(esize), .imm(imm), .result(result), .illegal(illegal));

// File: tb/elem_shuffle_unit_tb.sv
`timescale 1ns/1ps
module elem_shuffle_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [2:0]  opcode = '0;
  logic [1:0]  esize = '0;
  logic [7:0]  imm = '0;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  logic [64:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  elem_shuffle_unit #(.REG_OUT(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .opcode(opcode),
    .esize(esize), .imm(imm), .result(result), .illegal(illegal));

  function automatic longint unsigned getel(logic [63:0] x, int e, int bytes);
    longint unsigned v = 0;
    for (int t = 0; t < bytes; t++) v |= longint'(x[8*(e*bytes+t) +: 8]) << (8*t);
    return v;
  endfunction

  function automatic logic [63:0] putel(logic [63:0] x, int e, int bytes, longint unsigned v);
    for (int t = 0; t < bytes; t++) x[8*(e*bytes+t) +: 8] = 8'(v >> (8*t));
    return x;
  endfunction

  function automatic longint sclamp(longint v, longint lo, longint hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic string tagof(logic [2:0] op, logic [1:0] es, logic ill);
    if (ill) return "R9";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return (es == 2'd1) ? "R7" : "R8";
    endcase
  endfunction

  function automatic logic [64:0] model(logic [63:0] a, logic [63:0] b, logic [2:0] op,
                                        logic [1:0] es, logic [7:0] im);
    logic [63:0] r = '0;
    int bytes, n, src, w;
    longint v;
    int order[8];
    if (op <= 3'd3) begin
      if (es == 2'd3) return {1'b1, 64'd0};
      bytes = 1 << es; n = 8 / bytes;
      for (int j = 0; j < n; j++) begin
        if (op >= 3'd2) src = j / 2 + ((op == 3'd3) ? n / 2 : 0);
        else            src = (j / 2) * 2 + ((op == 3'd1) ? 1 : 0);
        r = putel(r, j, bytes, getel((j % 2) ? a : b, src, bytes));
      end
      return {1'b0, r};
    end
    if (op == 3'd4 || op == 3'd5) begin
      if (es > 2'd1 || (op == 3'd5 && es != 2'd0)) return {1'b1, 64'd0};
      w = (es == 2'd0) ? 2 : 4;
      n = 8 / w;
      for (int j = 0; j < 2 * n; j++) begin
        v = longint'(getel(j < n ? a : b, j % n, w));
        if (v >= (longint'(1) << (8*w - 1))) v -= longint'(1) << (8*w);
        if (op == 3'd5)      v = sclamp(v, 0, 255);
        else if (w == 2)     v = sclamp(v, -128, 127);
        else                 v = sclamp(v, -32768, 32767);
        r = putel(r, j, w / 2, longint'(v));
      end
      return {1'b0, r};
    end
    if (op == 3'd6 && es == 2'd1) begin
      for (int k = 0; k < 4; k++) r = putel(r, k, 2, getel(a, (im >> (2*k)) & 3, 2));
      return {1'b0, r};
    end
    if (op == 3'd6 && es == 2'd0) begin
      case (im[3:0])
        4'h0: order = '{0,0,0,0,0,0,0,0};
        4'h8: order = '{1,0,3,2,5,4,7,6};
        4'h9: order = '{0,4,1,5,2,6,3,7};
        4'hA: order = '{0,2,4,6,1,3,5,7};
        4'hB: order = '{7,6,5,4,3,2,1,0};
        default: return {1'b1, 64'd0};
      endcase
      for (int i = 0; i < 8; i++) r = putel(r, i, 1, getel(a, order[i], 1));
      return {1'b0, r};
    end
    return {1'b1, 64'd0};
  endfunction

  task automatic compare_prev();
    logic [64:0] e;
    string t;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if ({illegal, result} !== e) begin
      errors++;
      $display("FAIL %s: got ill=%0b res=%h, expected ill=%0b res=%h", t, illegal, result, e[64], e[63:0]);
    end
  endtask

  task automatic step(logic [63:0] a, logic [63:0] b, logic [2:0] op, logic [1:0] es, logic [7:0] im);
    logic [64:0] e;
    @(negedge clk);
    compare_prev();
    src_a = a; src_b = b; opcode = op; esize = es; imm = im;
    e = model(a, b, op, es, im);
    exp_q.push_back(e);
    tag_q.push_back(tagof(op, es, e[64]));
  endtask

  localparam logic [63:0] PA = 64'h8877_6655_4433_2211;
  localparam logic [63:0] PB = 64'hFFEE_DDCC_BBAA_9988;

  initial begin
    logic [7:0] im;
    src_a = PA; src_b = PB; opcode = 3'd7;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (result !== 64'd0 || illegal !== 1'b0) begin
      errors++;
      $display("FAIL R10: reset got res=%h ill=%0b, expected res=0 ill=0", result, illegal);
    end
    rst_n = 1'b1;
    for (int op = 0; op < 4; op++)
      for (int es = 0; es < 4; es++) step(PA, PB, 3'(op), 2'(es), 8'h00); // R1 R2 R3 R4 R9
    step({16'h0080, 16'hFF7F, 16'h007F, 16'hFF80}, {16'h7FFF, 16'h8000, 16'h0001, 16'hFFFF}, 3'd4, 2'd0, 8'h00); // R5
    step({32'h8000_0000, 32'h0000_8000}, {32'h0000_7FFF, 32'hFFFF_8000}, 3'd4, 2'd1, 8'h00); // R5
    step({16'hFFFF, 16'h0100, 16'h00FF, 16'h0080}, {16'h8000, 16'h7FFF, 16'h0000, 16'h0001}, 3'd5, 2'd0, 8'h00); // R6
    step(PA, PB, 3'd5, 2'd1, 8'h00); // R9
    step(PA, PB, 3'd4, 2'd2, 8'h00); // R9
    step(PA, PB, 3'd6, 2'd1, 8'hE4); // R7
    step(PA, PB, 3'd6, 2'd1, 8'h1B); // R7
    step(PA, PB, 3'd6, 2'd1, 8'hAA); // R7
    foreach (im_list[i]) step(PA, PB, 3'd6, 2'd0, im_list[i]); // R8 R9
    step(PA, PB, 3'd6, 2'd2, 8'h00); // R9
    step(PA, PB, 3'd7, 2'd0, 8'h00); // R9
    for (int n = 0; n < 3000; n++) begin
      im = 8'($urandom);
      if (n % 3 == 0) im[3:0] = 4'h8 + 4'($urandom_range(0, 3));
      step({$urandom, $urandom}, {$urandom, $urandom}, 3'($urandom), 2'($urandom), im); // R10
    end
    @(negedge clk);
    compare_prev();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [7:0] im_list[7] = '{8'h00, 8'hF0, 8'h08, 8'h19, 8'h0A, 8'h4B, 8'h05};

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule